// File: doc/BRIEF.md
# Backlight PWM Generator with Group-Locked Duty Update

This block produces a backlight pulse-width-modulated output from four small software registers. One register sets the period length and how many of its bits are significant. One holds a 16-bit, MSB-aligned active count, a fractional-duty switch and an output enable. One holds a group lock. The last holds a reference divider that slows the period counter. Software reaches all four through a plain single-cycle write port and a combinational read port.

Duty changes are staged. A write to the control register updates a programmed copy of the active count and raises an update-pending flag. That copy moves into the live duty only at the end of a PWM period, and only while the update is not locked. Software can lock the group, write a new duty and release the lock, so the change lands as one clean update. The group lock can also follow a chip-wide lock input, unless software tells it to ignore that input.

Top module: `bl_pwm`

## Requirements
- R1: After reset the register reads are as follows. Address 0 (period) reads 0x000C0FA0. Address 1 (control) reads 0xC000FA00. Address 2 (lock) reads 0. Address 3 (divider) reads 0. `updatePending` is 0, and the output is held high because the integer duty equals the period.
- R2: The period register has the period in bits [15:0] and a bit count N in bits [19:16]. N = 0 means 16. Only the low N bits of the period value P count. With fractional mode off and divider D, one PWM cycle lasts P·D clocks.
- R3: The control register has the active count in bits [15:0], fractional enable in bit 30 and output enable in bit 31. With bit 30 clear, the high time is (active >> (16−N))·D clocks, and the low 16−N bits have no effect.
- R4: With bit 30 set, the low 16−N bits are a fraction F of one count. Over any 2^(16−N) consecutive periods, the total high time is (I·2^(16−N) + F)·D clocks, where I is the integer part.
- R5: With bit 31 clear the output is low. With an active count of 0 the output is low.
- R6: Divider register bits [15:0] give D. The period counter advances once every D clocks, and D = 0 behaves as 1.
- R7: Lock register bit 0 is the group lock. While the lock is in effect, writes to the control register do not change the duty seen at the output.
- R8: Any control-register write sets the pending flag, seen on `updatePending` and on lock-register bit 8. The flag clears at the first period end at which the lock is not in effect, and the new duty starts from that period on. A write made in the same cycle as a transfer keeps the flag set.
- R9: When lock-register bit 1 is 0, a high `globalLock` also puts the lock in effect. When bit 1 is 1, `globalLock` is ignored.
- R10: The live duty changes only at a period end. No period mixes the old and new duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 period, 1 control, 2 lock, 3 divider) |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| globalLock | input | 1 | Chip-wide lock request |
| pwmOut | output | 1 | Backlight PWM output |
| updatePending | output | 1 | Staged duty not yet transferred |

## Verification
A software write to the control register can fall in the same clock as the period-end transfer of an earlier staged value. In that case the write must win the pending flag, and the live duty must take only the value staged before it. The random phase writes the duty at arbitrary points in the period, including right on a period end with short periods. Each write is judged by the pending flag clearing within one period and by the high time measured afterwards matching the last value written. Lock release is also made to land next to a period end, and the pending flag must still read 1 in the cycle that follows.

// File: rtl/bl_pwm_pkg.sv
`timescale 1ns/1ps
package bl_pwm_pkg;
  localparam int DUTY_W = 16;
  localparam logic [1:0] ADDR_PERIOD = 2'd0;
  localparam logic [1:0] ADDR_CTRL   = 2'd1;
  localparam logic [1:0] ADDR_LOCK   = 2'd2;
  localparam logic [1:0] ADDR_DIV    = 2'd3;
  localparam logic [31:0] CTRL_RST   = 32'hC000_FA00;
  localparam logic [31:0] PERIOD_RST = 32'h000C_0FA0;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;   // prescaler tick: advance period counter
    logic xfer;   // copy programmed duty into live duty
  } dpStrobe_t;
endpackage

// File: rtl/bl_pwm_ctrl.sv
`timescale 1ns/1ps
module bl_pwm_ctrl
  import bl_pwm_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              globalLock,
  input  logic              boundary,
  output dpStrobe_t         strobe,
  output logic [DUTY_W-1:0] periodEff,
  output logic [4:0]        nBits,
  output logic [DUTY_W-1:0] progDuty,
  output logic              fracEn,
  output logic              outEn,
  output logic              effLock,
  output logic              pending
);
  logic [DUTY_W-1:0] periodVal;
  logic [3:0]        bitCnt;
  logic              grpLock, ignGlobal;
  logic [DIV_W-1:0]  divVal, divEff, preCnt;
  logic              tickNow, xferNow;
  logic [DUTY_W-1:0] periodMask;
  logic              unusedWr;

  assign unusedWr   = ^regWrData[29:20];
  assign nBits      = (bitCnt == 4'd0) ? 5'd16 : {1'b0, bitCnt};
  assign periodMask = ~(16'hFFFF << nBits);
  assign periodEff  = periodVal & periodMask;
  assign effLock    = grpLock | (globalLock & ~ignGlobal);
  assign divEff     = (divVal == '0) ? DIV_W'(1) : divVal;
  assign tickNow    = (preCnt >= divEff - 1'b1);
  assign xferNow    = boundary & pending & ~effLock;
  assign strobe     = '{tick: tickNow, xfer: xferNow};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodVal <= PERIOD_RST[15:0];
      bitCnt    <= PERIOD_RST[19:16];
      progDuty  <= CTRL_RST[15:0];
      fracEn    <= CTRL_RST[30];
      outEn     <= CTRL_RST[31];
      grpLock   <= 1'b0;
      ignGlobal <= 1'b0;
      divVal    <= '0;
      pending   <= 1'b0;
      preCnt    <= '0;
    end else begin
      preCnt <= tickNow ? '0 : preCnt + 1'b1;
      if (xferNow) pending <= 1'b0;
      if (regWrEn) begin
        case (regAddr)
          ADDR_PERIOD: begin
            periodVal <= regWrData[15:0];
            bitCnt    <= regWrData[19:16];
          end
          ADDR_CTRL: begin
            progDuty <= regWrData[15:0];
            fracEn   <= regWrData[30];
            outEn    <= regWrData[31];
            pending  <= 1'b1;   // write wins over a same-cycle transfer
          end
          ADDR_LOCK: begin
            grpLock   <= regWrData[0];
            ignGlobal <= regWrData[1];
          end
          default: divVal <= regWrData[DIV_W-1:0];
        endcase
      end
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_PERIOD: regRdData = {12'd0, bitCnt, periodVal};
      ADDR_CTRL:   regRdData = {outEn, fracEn, 14'd0, progDuty};
      ADDR_LOCK:   regRdData = {23'd0, pending, 6'd0, ignGlobal, grpLock};
      default:     regRdData = 32'(divVal);
    endcase
  end
endmodule

// File: rtl/bl_pwm_dp.sv
`timescale 1ns/1ps
module bl_pwm_dp
  import bl_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DUTY_W-1:0] periodEff,
  input  logic [4:0]        nBits,
  input  logic [DUTY_W-1:0] progDuty,
  input  logic              fracEn,
  input  logic              outEn,
  output logic              boundary,
  output logic [DUTY_W-1:0] liveDuty,
  output logic              pwmOut
);
  logic [DUTY_W-1:0] periodCnt, acc, activeInt, fracPart;
  logic [DUTY_W:0]   accSum;
  logic [4:0]        shAmt;
  logic              extra, highNow;

  assign shAmt     = 5'd16 - nBits;
  assign activeInt = liveDuty >> shAmt;
  // fraction left-aligned so the accumulator wraps at one count
  assign fracPart  = fracEn ? (liveDuty << nBits) : '0;
  assign accSum    = {1'b0, acc} + {1'b0, fracPart};
  assign boundary  = strobe.tick &&
                     (({1'b0, periodCnt} + 17'd1) >= {1'b0, periodEff});
  assign highNow   = {1'b0, periodCnt} < ({1'b0, activeInt} + {16'd0, extra});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodCnt <= '0;
      liveDuty  <= CTRL_RST[15:0];
      acc       <= '0;
      extra     <= 1'b0;
      pwmOut    <= 1'b0;
    end else begin
      if (strobe.tick) periodCnt <= boundary ? '0 : periodCnt + 1'b1;
      if (strobe.xfer) liveDuty <= progDuty;
      if (boundary) begin
        acc   <= accSum[DUTY_W-1:0];
        extra <= accSum[DUTY_W];
      end
      pwmOut <= outEn & highNow;
    end
  end
endmodule

// File: rtl/bl_pwm.sv
`timescale 1ns/1ps
module bl_pwm
  import bl_pwm_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        globalLock,
  output logic        pwmOut,
  output logic        updatePending
);
  dpStrobe_t         strobe;
  logic [DUTY_W-1:0] periodEff, progDuty, liveDuty;
  logic [4:0]        nBits;
  logic              fracEn, outEn, effLock, boundary;

  bl_pwm_ctrl #(.DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .globalLock(globalLock),
    .boundary(boundary), .strobe(strobe), .periodEff(periodEff),
    .nBits(nBits), .progDuty(progDuty), .fracEn(fracEn), .outEn(outEn),
    .effLock(effLock), .pending(updatePending)
  );

  bl_pwm_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .periodEff(periodEff),
    .nBits(nBits), .progDuty(progDuty), .fracEn(fracEn), .outEn(outEn),
    .boundary(boundary), .liveDuty(liveDuty), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/bl_pwm_chk.sv
`timescale 1ns/1ps
module bl_pwm_chk (
  input logic        clk,
  input logic        rstN,
  input logic        boundary,
  input logic        effLock,
  input logic [15:0] liveDuty,
  input logic        outEn,
  input logic        pwmOut,
  input logic        pending
);
  AST_LIVE_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    !boundary |=> $stable(liveDuty));                                   // R10
  AST_LOCK_HOLDS_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    effLock |=> $stable(liveDuty));                                     // R7
  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |=> !pwmOut);                                                // R5
  AST_PENDING_CLEARS_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pending) |-> ($past(boundary) && !$past(effLock)));           // R8
  AST_PENDING_HOLDS_WHILE_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (pending && effLock) |=> pending);                                  // R8
endmodule

bind bl_pwm bl_pwm_chk chk_i (
  .clk(clk), .rstN(rstN), .boundary(boundary), .effLock(effLock),
  .liveDuty(liveDuty), .outEn(outEn), .pwmOut(pwmOut), .pending(updatePending)
);

// File: tb/bl_pwm_tb_top.sv
`timescale 1ns/1ps
module bl_pwm_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        globalLock = 1'b0;
  logic        pwmOut, updatePending;
  int          nChecks = 0;
  int          nFail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  bl_pwm dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .globalLock(globalLock),
    .pwmOut(pwmOut), .updatePending(updatePending)
  );

  function automatic logic [31:0] ctrlWord(bit en, bit frac, logic [15:0] act);
    return {en, frac, 14'd0, act};
  endfunction
  function automatic logic [31:0] periodWord(int n, logic [15:0] p);
    logic [3:0] f = (n == 16) ? 4'd0 : 4'(n);
    return {12'd0, f, p};
  endfunction
  function automatic int expHigh(logic [15:0] act, int n, int d);
    return int'(act >> (16 - n)) * d;
  endfunction
  function automatic int expFracSum(logic [15:0] act, int n, int d);
    int k = 1 << (16 - n);
    return (int'(act >> (16 - n)) * k + int'(act & 16'(k - 1))) * d;
  endfunction

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitClear(string req);
    int g = 0;
    while (updatePending && g < 20000) begin @(negedge clk); g++; end
    chk(req, int'(updatePending), 0);
    repeat (3) @(negedge clk);
  endtask

  // measure k consecutive periods from a rising edge
  task automatic measure(int k, output int hi, output int per);
    int  guard = 0;
    bit  prev;
    @(negedge clk); prev = pwmOut;
    forever begin
      @(negedge clk); guard++;
      if ((!prev && pwmOut) || guard > 30000) break;
      prev = pwmOut;
    end
    hi = 1; per = 1; prev = 1'b1;
    for (int p = 0; p < k; ) begin
      @(negedge clk); guard++;
      if (guard > 60000) break;
      if (!prev && pwmOut) p++;
      if (p < k) begin per++; if (pwmOut) hi++; end
      prev = pwmOut;
    end
  endtask

  task automatic countHigh(int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (pwmOut) hi++; end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int hi, per;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rdReg(2'd0, rd); chk("R1 period reg", rd, 32'h000C0FA0);
    rdReg(2'd1, rd); chk("R1 ctrl reg", rd, 32'hC000FA00);
    rdReg(2'd2, rd); chk("R1 lock reg", rd, 0);
    rdReg(2'd3, rd); chk("R1 div reg", rd, 0);
    chk("R1 pending", int'(updatePending), 0);
    chk("R1 output high", int'(pwmOut), 1);

    // R2 / R3 basic, N=12, P=20, D=1
    wrReg(2'd3, 32'd1);
    wrReg(2'd0, periodWord(12, 16'd20));
    wrReg(2'd1, ctrlWord(1, 0, 16'h0050));
    chk("R8 pending set after write", int'(updatePending), 1);
    waitClear("R8 pending clears");
    measure(1, hi, per);
    chk("R3 high N12", hi, expHigh(16'h0050, 12, 1));
    chk("R2 period N12", per, 20);

    // R7 / R8 lock
    wrReg(2'd2, 32'd1);
    wrReg(2'd1, ctrlWord(1, 0, 16'h00C0));
    repeat (100) @(negedge clk);
    measure(1, hi, per);
    chk("R7 locked duty unchanged", hi, 5);
    chk("R8 pending while locked", int'(updatePending), 1);
    rdReg(2'd2, rd); chk("R8 pending in lock reg bit 8", int'(rd[8]), 1);
    wrReg(2'd2, 32'd0);
    chk("R8 pending right after release", int'(updatePending), 1);
    waitClear("R8 clear after release");
    measure(1, hi, per);
    chk("R8 new duty after release", hi, 12);

    // R9 global lock
    globalLock = 1'b1;
    wrReg(2'd1, ctrlWord(1, 0, 16'h0070));
    repeat (100) @(negedge clk);
    measure(1, hi, per);
    chk("R9 global lock holds duty", hi, 12);
    chk("R9 pending under global lock", int'(updatePending), 1);
    wrReg(2'd2, 32'd2);
    waitClear("R9 ignore global releases");
    measure(1, hi, per);
    chk("R9 duty after ignore", hi, 7);
    globalLock = 1'b0;
    wrReg(2'd2, 32'd0);

    // R4 fractional: int 6, fraction 5/16
    wrReg(2'd1, ctrlWord(1, 1, 16'h0065));
    waitClear("R4 pending");
    measure(16, hi, per);
    chk("R4 fractional sum", hi, expFracSum(16'h0065, 12, 1));
    chk("R4 window length", per, 320);

    // R6 divider
    wrReg(2'd3, 32'd3);
    wrReg(2'd0, periodWord(12, 16'd10));
    wrReg(2'd1, ctrlWord(1, 0, 16'h0040));
    waitClear("R6 pending");
    measure(1, hi, per);
    chk("R6 high D3", hi, 12);
    chk("R6 period D3", per, 30);
    wrReg(2'd3, 32'd0);
    measure(1, hi, per); measure(1, hi, per);
    chk("R6 divider zero as one", per, 10);

    // R2 bit count 0 means 16; N=4 masks upper period bits
    wrReg(2'd0, periodWord(16, 16'd24));
    wrReg(2'd1, ctrlWord(1, 0, 16'h0009));
    waitClear("R2 pending");
    measure(1, hi, per);
    chk("R2 N16 period", per, 24);
    chk("R3 N16 high", hi, 9);
    wrReg(2'd0, periodWord(4, 16'hFF0A));
    wrReg(2'd1, ctrlWord(1, 0, 16'h3FFF));
    waitClear("R2 pending N4");
    measure(1, hi, per);
    chk("R2 N4 masked period", per, 10);
    chk("R3 N4 low bits ignored", hi, 3);

    // R5 enable off and zero duty
    wrReg(2'd1, ctrlWord(0, 0, 16'h7000));
    waitClear("R5 pending");
    countHigh(60, hi);
    chk("R5 disabled low", hi, 0);
    wrReg(2'd1, ctrlWord(1, 0, 16'h0000));
    waitClear("R5 pending zero");
    repeat (12) @(negedge clk);
    countHigh(60, hi);
    chk("R5 zero duty low", hi, 0);

    // random phase (R2, R3, R6, R10), writes at arbitrary phase
    for (int it = 0; it < 30; it++) begin
      int n   = 4 + int'($urandom % 13);
      int mx  = ((1 << n) - 1 < 60) ? (1 << n) - 1 : 60;
      int p   = 8 + int'($urandom % unsigned'(mx - 7));
      int a   = 1 + int'($urandom % unsigned'(p - 1));
      int dv  = int'($urandom % 4);
      int d   = (dv == 0) ? 1 : dv;
      logic [15:0] pf  = 16'(p);
      logic [15:0] act = 16'(a << (16 - n));
      if (n < 16) begin
        pf  = pf | (16'($urandom) << n);
        act = act | (16'($urandom) & 16'((1 << (16 - n)) - 1));
      end
      repeat (int'($urandom % 7)) @(negedge clk);
      wrReg(2'd3, 32'(dv));
      wrReg(2'd0, periodWord(n, pf));
      wrReg(2'd1, ctrlWord(1, 0, act));
      waitClear("R10 random pending");
      measure(1, hi, per);
      chk("R3 random high", hi, expHigh(act, n, d));
      chk("R2 random period", per, p * d);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule